// File: doc/BRIEF.md
# Detect-Word Parallel Word Aligner

The block sits behind a deserializer whose word boundary is arbitrary and moves after every power-up. Each valid input word is joined with the previous valid word to form a window twice the word width. A programmable detect word, such as an 8B/10B comma, is compared under a per-bit mask against every bit rotation of that window in the same cycle. No start signal from the far end is needed and the link latency does not have to be known.

On the first hit the block latches the rotation and from then on emits one realigned word per valid input word. A one-cycle marker flags the first aligned word, which is the word that matched, so downstream error processing knows where to begin. The offset stays fixed until a rearm pulse drops the lock and the search starts again.

Bits travel in arrival order: `data_i[0]` is the earliest bit of a word. In the window, bits 0..W-1 hold the previous word and bits W..2W-1 hold the current one. The candidate at offset k is window bits k..k+W-1.

Top module: `word_aligner`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `start_o` and `locked_o` are 0, and `offset_o` and `data_o` are all zeros.
- R2: While unlocked, `valid_o` and `start_o` stay 0 when no offset matches.
- R3: In an unlocked cycle with `valid_i`=1 and at least one earlier valid word since reset, offset k matches when candidate bit j equals `det_word_i[j]` for every j where `det_mask_i[j]`=1. On a match, after the next clock edge `locked_o`=1, `valid_o`=1, `start_o`=1, `offset_o`=k and `data_o` is candidate k.
- R4: While locked, each valid input word produces `valid_o`=1 after the next edge, with `data_o` = window bits `offset_o`..`offset_o`+W-1 and `start_o`=0.
- R5: While locked, later matches at any offset are ignored: `offset_o` and `locked_o` keep their values.
- R6: A cycle with `rearm_i`=1 clears `locked_o` and gives `valid_o`=0 after the edge. The search resumes with the next valid word, and the word presented during the rearm cycle still becomes the previous word.
- R7: Bits with `det_mask_i`=0 are don't-care. A mask covering only bits 0..6 matches a comma whose last three bits differ.
- R8: When several offsets match in the same cycle, the lowest offset is locked.
- R9: A cycle with `valid_i`=0 and `rearm_i`=0 gives `valid_o`=0 and changes neither the lock, the offset nor the stored previous word.
- R10: The first valid word after reset is never matched, even with an all-zero mask. With an all-zero mask the second valid word locks at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word present |
| data_i | input | W | Raw deserialized word, bit 0 earliest |
| det_word_i | input | W | Detect word to search for |
| det_mask_i | input | W | Per-bit compare enable for the detect word |
| rearm_i | input | 1 | Drop the lock and restart the search |
| valid_o | output | 1 | Aligned word valid |
| data_o | output | W | Realigned word |
| start_o | output | 1 | First aligned word after lock |
| locked_o | output | 1 | Offset is locked |
| offset_o | output | $clog2(W) | Locked bit offset |

## Verification
A wrong stored previous word or a slip in the latched offset corrupts `data_o` on the very next valid word. The bench compares every output word against the bit stream it generated, so such a fault shows within one cycle. A priority or mask fault appears in the lock cycle as a wrong `offset_o` or as a missing or early `start_o`. A lock that is not held, or a rearm that is not honoured, shows as `offset_o` moving on a later detect word or as `valid_o` staying high one cycle after the rearm.

// File: rtl/walign_pkg.sv
package walign_pkg;
  localparam int DEF_W = 10;
  typedef enum logic {ST_SEEK = 1'b0, ST_LOCK = 1'b1} lock_st_e;
endpackage

// File: rtl/walign_window.sv
module walign_window #(
  parameter int W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   data_i,
  output logic [2*W-1:0] win_o,
  output logic           primed_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (valid_i) begin
      prev_q   <= data_i;
      primed_q <= 1'b1;
    end
  end

  // older word in the low half
  assign win_o    = {data_i, prev_q};
  assign primed_o = primed_q;

  a_r9_prev_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prev_q) && $stable(primed_q));
endmodule

// File: rtl/walign_match.sv
module walign_match #(
  parameter int W = 10
) (
  input  logic [2*W-1:0] win_i,
  input  logic [W-1:0]   det_i,
  input  logic [W-1:0]   mask_i,
  output logic [W-1:0]   hit_o
);
  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit_o[k] = ~|((win_i[k +: W] ^ det_i) & mask_i);
  end
endmodule

// File: rtl/walign_prio.sv
module walign_prio #(
  parameter int W  = 10,
  parameter int OW = $clog2(W)
) (
  input  logic [W-1:0]  hit_i,
  output logic [OW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = OW'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/word_aligner.sv
module word_aligner
  import walign_pkg::*;
#(
  parameter int W  = DEF_W,
  parameter int OW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  det_word_i,
  input  logic [W-1:0]  det_mask_i,
  input  logic          rearm_i,
  output logic          valid_o,
  output logic [W-1:0]  data_o,
  output logic          start_o,
  output logic          locked_o,
  output logic [OW-1:0] offset_o
);
  logic [2*W-1:0] win;
  logic           primed;
  logic [W-1:0]   hit;
  logic [OW-1:0]  hit_idx;
  logic           hit_any;
  logic [OW-1:0]  sel;
  lock_st_e       st_q;
  logic [OW-1:0]  off_q;
  logic [W-1:0]   data_q;
  logic           valid_q, start_q;

  walign_window #(.W(W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .win_o(win), .primed_o(primed));

  walign_match #(.W(W)) u_match (
    .win_i(win), .det_i(det_word_i), .mask_i(det_mask_i), .hit_o(hit));

  walign_prio #(.W(W), .OW(OW)) u_prio (
    .hit_i(hit), .idx_o(hit_idx), .any_o(hit_any));

  assign sel = (st_q == ST_LOCK) ? off_q : hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SEEK;
      off_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
      if (rearm_i) begin
        st_q <= ST_SEEK;
      end else if (valid_i) begin
        if (st_q == ST_LOCK) begin
          valid_q <= 1'b1;
          data_q  <= win[sel +: W];
        end else if (primed && hit_any) begin
          st_q    <= ST_LOCK;
          off_q   <= hit_idx;
          valid_q <= 1'b1;
          start_q <= 1'b1;
          data_q  <= win[sel +: W];
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign start_o  = start_q;
  assign locked_o = (st_q == ST_LOCK);
  assign offset_o = off_q;

  a_r2_valid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o);
  a_r3_start_on_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> start_o && valid_o);
  a_r5_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !rearm_i |=> locked_o && $stable(offset_o));
  a_r6_rearm_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !locked_o && !valid_o);
  a_r8_lowest_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_any |-> hit[hit_idx] && $countones(hit & ((W'(1) << hit_idx) - W'(1))) == 0);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !rearm_i |=> !valid_o && !start_o && $stable(locked_o));
endmodule

// File: tb/word_aligner_test.sv
module word_aligner_test;
  localparam int W  = 10;
  localparam int OW = $clog2(W);
  localparam int NB = W * 32;
  localparam logic [W-1:0] COMMA = 10'b0101111100; // arrival order 0011111010
  localparam logic [W-1:0] ALT   = 10'b1001111100; // arrival order 0011111001

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] data_i = '0, det_word_i = '0, det_mask_i = '0;
  logic rearm_i = 1'b0;
  logic valid_o, start_o, locked_o;
  logic [W-1:0] data_o;
  logic [OW-1:0] offset_o;

  int n_chk = 0, n_fail = 0;
  logic s [0:NB-1];

  always #10 clk = ~clk;

  word_aligner #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .det_word_i(det_word_i), .det_mask_i(det_mask_i), .rearm_i(rearm_i),
    .valid_o(valid_o), .data_o(data_o), .start_o(start_o),
    .locked_o(locked_o), .offset_o(offset_o));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] bits_at(int pos);
    logic [W-1:0] v;
    for (int j = 0; j < W; j++) v[j] = s[pos + j];
    return v;
  endfunction

  function automatic bit cand_hit(int pos, logic [W-1:0] det, logic [W-1:0] msk);
    for (int j = 0; j < W; j++)
      if (msk[j] && s[pos + j] != det[j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; rearm_i = 1'b0; data_i = '0;
    #25;
    check("R1", "valid_o", 32'(valid_o), 0);
    check("R1", "start_o", 32'(start_o), 0);
    check("R1", "locked_o", 32'(locked_o), 0);
    check("R1", "offset_o", 32'(offset_o), 0);
    check("R1", "data_o", 32'(data_o), 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  // p1/p2: bit positions of detect words (-1 none); pat: word written there
  task automatic run_case(string tag, int p1, int p2, logic [W-1:0] pat,
                          logic [W-1:0] det, logic [W-1:0] msk,
                          int rearm_at, bit gaps, int nwords);
    int n = 0, step = 0;
    bit e_lock = 0;
    int e_off = 0;
    for (int i = 0; i < NB; i++) s[i] = (p1 >= 0 && i >= p1 + W) ? (((i * 5) % 7) < 3) : 1'b0;
    if (p1 >= 0) for (int j = 0; j < W; j++) s[p1 + j] = pat[j];
    if (p2 >= 0) for (int j = 0; j < W; j++) s[p2 + j] = pat[j];
    det_word_i = det; det_mask_i = msk;
    do_reset();
    while (n < nwords) begin
      bit idle, rearm, e_valid, e_start;
      logic [W-1:0] e_data;
      string req;
      idle  = gaps && (step % 3 == 2);
      rearm = !idle && (n == rearm_at);
      e_valid = 0; e_start = 0; e_data = '0; req = "R2";
      @(negedge clk);
      valid_i = !idle; rearm_i = rearm;
      data_i  = idle ? 10'h2A5 : bits_at(n * W);
      if (idle) req = "R9";
      else if (rearm) begin
        e_lock = 0; req = "R6"; n++;
      end else begin
        if (e_lock) begin
          e_valid = 1; e_data = bits_at((n - 1) * W + e_off); req = "R4";
        end else if (n >= 1) begin
          for (int k = 0; k < W; k++) begin
            if (!e_lock && cand_hit((n - 1) * W + k, det, msk)) begin
              e_lock = 1; e_off = k; e_valid = 1; e_start = 1;
              e_data = bits_at((n - 1) * W + k); req = "R3";
            end
          end
        end
        n++;
      end
      @(posedge clk); #1;
      req = {req, " ", tag};
      check(req, "valid_o", 32'(valid_o), 32'(e_valid));
      check(req, "start_o", 32'(start_o), 32'(e_start));
      check(req, "locked_o", 32'(locked_o), 32'(e_lock));
      if (e_lock) check(req, "offset_o", 32'(offset_o), 32'(e_off));
      if (e_valid) check(req, "data_o", 32'(data_o), 32'(e_data));
      step++;
    end
    @(negedge clk); valid_i = 1'b0; rearm_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // every bit phase, full compare
    for (int ph = 0; ph < W; ph++)
      run_case("R3 phase", 20 + ph, -1, COMMA, COMMA, '1, -1, 0, 10);
    // second detect word at another phase is ignored
    run_case("R5", 23, 57, COMMA, COMMA, '1, -1, 0, 12);
    // rearm, then relock at the new phase
    run_case("R6", 23, 77, COMMA, COMMA, '1, 5, 0, 14);
    // 7-bit prefix mask accepts a variant; full mask rejects it
    run_case("R7", 34, -1, ALT, COMMA, 10'h07F, -1, 0, 10);
    run_case("R7 full-mask", 34, -1, ALT, COMMA, '1, -1, 0, 10);
    // two hits in one window (bits 13 and 16): lowest offset wins
    for (int i = 0; i < NB; i++) s[i] = 1'b0;
    run_case("R8", 13, 16, 10'h001, 10'h001, 10'h001, -1, 0, 6);
    // all-zero mask: first word never matches, second locks at 0
    run_case("R10", 20, -1, COMMA, COMMA, '0, -1, 0, 6);
    // idle cycles interleaved
    run_case("R9", 25, -1, COMMA, COMMA, '1, -1, 1, 12);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule